// File: doc/BRIEF.md
# Timer Count-Clock Prescaler

This block makes the count-enable strobe for a single timer channel. Two clock sources, one slow and one fast, both arrive as one-cycle tick pulses in the system clock domain. A source-select bit picks one of them. A divider then passes every Nth tick of that source. N comes from a 3-bit ratio code, and the table of ratios differs between the slow source and the fast source.

A second select bit chooses between the divided internal ticks and an external event input, which is used for event counting. An enable bit gates the chosen event stream. The result is a registered strobe, one system cycle wide, that the timer's down counter uses as its count enable.

A change to the ratio code or to the source clears the divide counter. The first strobe under the new setting therefore always comes after a full period of the new ratio.

Top module: `tclk_prescaler`

## Requirements
- R1: With `src_slow_i`=1 the divider counts `slow_tick_i` pulses, and with `src_slow_i`=0 it counts `fast_tick_i` pulses. Ticks on the source that is not selected have no effect on the strobe count.
- R2: With the slow source, code value c divides the tick rate by 2^c. Codes 0 to 7 give 1, 2, 4, 8, 16, 32, 64 and 128.
- R3: With the fast source, codes 0 to 7 divide the tick rate by 1, 2, 8, 32, 64, 256, 1024 and 4096.
- R4: With `ext_sel_i`=0 the strobe follows the divided ticks. With `ext_sel_i`=1 it follows rising edges of `ext_event_i` sampled on `clk`: one strobe for each 0-to-1 transition, whatever the pulse width.
- R5: While `run_en_i`=0 no strobe is produced.
- R6: A strobe rises on the clock edge that follows the qualifying tick or edge. Each event gives exactly one high cycle.
- R7: Any change of `ratio_code_i` or `src_slow_i` clears the divide counter. After the change, the first strobe comes only after a full period of the new ratio.
- R8: While reset is asserted, and after it is released, the strobe is low and the divide counter starts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick_i | input | 1 | One-cycle tick pulse from the slow source |
| fast_tick_i | input | 1 | One-cycle tick pulse from the fast source |
| src_slow_i | input | 1 | Source select: 1 selects slow, 0 selects fast |
| ratio_code_i | input | 3 | Division ratio code |
| ext_sel_i | input | 1 | Input select: 0 selects the prescaler, 1 selects the external event |
| ext_event_i | input | 1 | External event level, synchronous to `clk` |
| run_en_i | input | 1 | Enable gate for the count strobe |
| count_strobe_o | output | 1 | One-cycle count-enable strobe |

## Verification
The assertions assume three things about the inputs:
- The tick inputs and `ext_event_i` are already synchronous to `clk`.
- The configuration inputs change only on clock edges.
- The divide counter therefore never sees a ratio change that it has not itself detected.

The bench drives every input from the falling clock edge, so each input is stable across a full rising edge. It spaces the ticks randomly with gaps of one cycle or more from a fixed seed, and at random it also pulses the source that is not selected. Before each measurement window it holds every configuration input steady for idle cycles.

// File: rtl/tclk_pkg.sv
package tclk_pkg;
  localparam int CODE_W    = 3;
  localparam int MAX_SHIFT = 12;
  localparam int RATIO_W   = MAX_SHIFT + 1;
  localparam int CNT_W     = MAX_SHIFT;

  typedef struct packed {
    logic              slow;
    logic [CODE_W-1:0] code;
  } cfg_t;

  // log2 of the divide ratio when the fast source is selected
  function automatic int fast_shift(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    return 0;
      3'd1:    return 1;
      3'd2:    return 3;
      3'd3:    return 5;
      3'd4:    return 6;
      3'd5:    return 8;
      3'd6:    return 10;
      default: return 12;
    endcase
  endfunction

  function automatic logic [RATIO_W-1:0] ratio_of(input cfg_t cfg);
    int sh;
    sh = cfg.slow ? int'(cfg.code) : fast_shift(cfg.code);
    return RATIO_W'(1) << sh;
  endfunction
endpackage

// File: rtl/tclk_src_mux.sv
module tclk_src_mux (
  input  logic slow_tick_i,
  input  logic fast_tick_i,
  input  logic src_slow_i,
  output logic tick_o
);
  always_comb tick_o = src_slow_i ? slow_tick_i : fast_tick_i;
endmodule

// File: rtl/tclk_divider.sv
module tclk_divider
  import tclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_t             cfg_i,
  input  logic             tick_i,
  output logic             pulse_o,
  output logic             cfg_change_o,
  output logic [CNT_W-1:0] cnt_o
);
  cfg_t             cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_val;
  logic             at_last;

  always_comb begin
    last_val     = CNT_W'(ratio_of(cfg_i) - RATIO_W'(1));
    cfg_change_o = (cfg_i != cfg_q);
    at_last      = (cnt_q == last_val);
    pulse_o      = tick_i && at_last && !cfg_change_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else begin
      cfg_q <= cfg_i;
      if (cfg_change_o)  cnt_q <= '0;
      else if (tick_i)   cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tclk_edge_det.sv
module tclk_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_i;
  end
  assign rise_o = level_i && !level_q;
endmodule

// File: rtl/tclk_prescaler.sv
module tclk_prescaler
  import tclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick_i,
  input  logic              fast_tick_i,
  input  logic              src_slow_i,
  input  logic [CODE_W-1:0] ratio_code_i,
  input  logic              ext_sel_i,
  input  logic              ext_event_i,
  input  logic              run_en_i,
  output logic              count_strobe_o
);
  cfg_t             cfg;
  logic             src_tick;
  logic             div_pulse;
  logic             cfg_change;
  logic [CNT_W-1:0] div_cnt;
  logic             ext_rise;
  logic             event_sel;

  assign cfg.slow = src_slow_i;
  assign cfg.code = ratio_code_i;

  tclk_src_mux u_mux (
    .slow_tick_i (slow_tick_i),
    .fast_tick_i (fast_tick_i),
    .src_slow_i  (src_slow_i),
    .tick_o      (src_tick)
  );

  tclk_divider u_div (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_i        (cfg),
    .tick_i       (src_tick),
    .pulse_o      (div_pulse),
    .cfg_change_o (cfg_change),
    .cnt_o        (div_cnt)
  );

  tclk_edge_det u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (ext_event_i),
    .rise_o  (ext_rise)
  );

  assign event_sel = ext_sel_i ? ext_rise : div_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_strobe_o <= 1'b0;
    else        count_strobe_o <= run_en_i && event_sel;
  end
endmodule

// File: rtl/tclk_prescaler_chk.sv
module tclk_prescaler_chk
  import tclk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             slow_tick_i,
  input logic             fast_tick_i,
  input logic             src_slow_i,
  input logic [CODE_W-1:0] ratio_code_i,
  input logic             ext_sel_i,
  input logic             run_en_i,
  input logic             count_strobe_o,
  input logic             div_pulse,
  input logic             cfg_change,
  input logic             ext_rise,
  input logic [CNT_W-1:0] div_cnt
);
  cfg_t cur;
  assign cur.slow = src_slow_i;
  assign cur.code = ratio_code_i;

  assert_src_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> (src_slow_i ? slow_tick_i : fast_tick_i));

  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_change |-> ({1'b0, div_cnt} < ratio_of(cur)));

  assert_int_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sel_i && run_en_i && div_pulse) |=> count_strobe_o);

  assert_ext_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel_i && run_en_i && ext_rise) |=> count_strobe_o);

  assert_gate_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en_i |=> !count_strobe_o);

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_change |=> (div_cnt == '0));

  assert_no_early_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_change |-> !div_pulse);
endmodule

bind tclk_prescaler tclk_prescaler_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .slow_tick_i    (slow_tick_i),
  .fast_tick_i    (fast_tick_i),
  .src_slow_i     (src_slow_i),
  .ratio_code_i   (ratio_code_i),
  .ext_sel_i      (ext_sel_i),
  .run_en_i       (run_en_i),
  .count_strobe_o (count_strobe_o),
  .div_pulse      (div_pulse),
  .cfg_change     (cfg_change),
  .ext_rise       (ext_rise),
  .div_cnt        (div_cnt)
);

// File: tb/tclk_prescaler_tb.sv
module tclk_prescaler_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_tick = 1'b0, fast_tick = 1'b0;
  logic       src_slow = 1'b1;
  logic [2:0] code = 3'd0;
  logic       ext_sel = 1'b0, ext_ev = 1'b0, run_en = 1'b0;
  logic       strobe;

  int errors = 0;
  int checks = 0;
  int strobes = 0;
  bit counting = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tclk_prescaler u_dut (
    .clk(clk), .rst_n(rst_n), .slow_tick_i(slow_tick), .fast_tick_i(fast_tick),
    .src_slow_i(src_slow), .ratio_code_i(code), .ext_sel_i(ext_sel),
    .ext_event_i(ext_ev), .run_en_i(run_en), .count_strobe_o(strobe)
  );

  always @(negedge clk) if (counting && strobe) strobes++;

  function automatic int exp_ratio(input bit slow, input int c);
    int fast_tab [8] = '{1, 2, 8, 32, 64, 256, 1024, 4096};
    int slow_tab [8] = '{1, 2, 4, 8, 16, 32, 64, 128};
    return slow ? slow_tab[c] : fast_tab[c];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      slow_tick = 1'b0; fast_tick = 1'b0; ext_ev = 1'b0;
    end
  endtask

  // Deliver n ticks on the selected source, with random gaps and random
  // ticks on the other source, then let the last strobe settle.
  task automatic deliver(input int n);
    int sent = 0;
    while (sent < n) begin
      @(negedge clk);
      if ($urandom % 3 != 0) begin
        if (src_slow) begin slow_tick = 1'b1; fast_tick = ($urandom % 2) == 1; end
        else          begin fast_tick = 1'b1; slow_tick = ($urandom % 2) == 1; end
        sent++;
      end else begin
        slow_tick = 1'b0; fast_tick = 1'b0;
      end
    end
    idle(3);
  endtask

  task automatic window(input bit slow, input int c, input string req);
    int r, n;
    @(negedge clk);
    src_slow = slow; code = 3'(c);
    idle(2);
    r = exp_ratio(slow, c);
    n = 2 * r + int'($urandom % r);
    strobes = 0; counting = 1'b1;
    deliver(n);
    counting = 1'b0;
    check(req, strobes, n / r);
  endtask

  initial begin
    void'($urandom(32'd1234));
    idle(3);
    check("R8 strobe in reset", int'(strobe), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    check("R8 strobe after reset", int'(strobe), 0);
    run_en = 1'b1;

    for (int c = 0; c < 8; c++) window(1'b1, c, "R2 slow ratio");
    for (int c = 0; c < 8; c++) window(1'b0, c, "R3 fast ratio");

    // R6: latency and width with ratio 1
    @(negedge clk); src_slow = 1'b1; code = 3'd0; idle(2);
    @(negedge clk); slow_tick = 1'b1;
    @(negedge clk); slow_tick = 1'b0;
    check("R6 strobe one cycle after tick", int'(strobe), 1);
    @(negedge clk);
    check("R6 strobe one cycle wide", int'(strobe), 0);

    // R1: only the other source ticks -> nothing
    @(negedge clk); src_slow = 1'b1; code = 3'd0; idle(2);
    strobes = 0; counting = 1'b1;
    for (int i = 0; i < 40; i++) begin @(negedge clk); fast_tick = 1'b1; end
    idle(3); counting = 1'b0;
    check("R1 unselected source ignored", strobes, 0);

    // R7: partial count under ratio 8, switch to 16, no early strobe
    @(negedge clk); src_slow = 1'b1; code = 3'd3; idle(2);
    strobes = 0; counting = 1'b1;
    deliver(7);
    @(negedge clk); code = 3'd4; idle(2);
    deliver(15);
    check("R7 no early strobe after change", strobes, 0);
    deliver(1);
    counting = 1'b0;
    check("R7 strobe after full new period", strobes, 1);

    // R5: gate off
    @(negedge clk); src_slow = 1'b1; code = 3'd0; run_en = 1'b0; idle(2);
    strobes = 0; counting = 1'b1;
    deliver(30);
    counting = 1'b0;
    check("R5 gated off", strobes, 0);
    run_en = 1'b1;

    // R4: external events with varied widths, ticks ignored
    @(negedge clk); ext_sel = 1'b1; idle(2);
    strobes = 0; counting = 1'b1;
    for (int p = 0; p < 6; p++) begin
      int hi = 1 + int'($urandom % 4);
      int lo = 1 + int'($urandom % 3);
      for (int i = 0; i < hi; i++) begin @(negedge clk); ext_ev = 1'b1; slow_tick = 1'b1; end
      for (int i = 0; i < lo; i++) begin @(negedge clk); ext_ev = 1'b0; slow_tick = 1'b1; end
    end
    idle(3); counting = 1'b0;
    check("R4 external edges counted", strobes, 6);
    ext_sel = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule